// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block holds the eight-bit status register of a serial non-volatile memory and decides, cycle by cycle, whether a program request from the serial command engine may proceed. The engine decodes commands and raises one-cycle strobes. These strobes set or clear the write-enable latch, commit a status-register write with its data byte, commit an array write at a target address, or report that the running program cycle has finished. The controller answers with two permission flags, one for the array and one for the status register, and with a busy flag. It also returns the status byte that the engine shifts out on a status read.

Array protection comes from a two-bit block-protect field, which covers none, the top quarter, the top half or all of the array. A lock bit combined with the active-low write-protect pin freezes the status register. A low-supply flag aborts any running cycle and drops the write-enable latch. A status write is held pending until its program cycle completes, so status reads keep showing the old protection bits during the cycle.

Top module: `wps_status_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 and busy is low, which means lock bit 0, block-protect 00, write-enable 0 and in-progress 0.
- R2: The write-enable bit (status bit 1) is set only by the set strobe and cleared by the clear strobe. Both strobes are ignored while busy.
- R3: When the done strobe arrives while busy, the in-progress bit (status bit 0) and the write-enable bit both read 0 after the next clock edge.
- R4: The low-supply flag wins over every other input. After the edge, write-enable and in-progress are 0 and any pending status write is discarded.
- R5: The status byte is laid out as lock bit in bit 7, zeros in bits 6 to 4, block-protect in bits 3:2, write-enable in bit 1 and in-progress in bit 0. A status write takes only data bits 7, 3 and 2.
- R6: While a status-write cycle runs, bits 7 and 3:2 keep their old values. The new values appear on the edge that ends the cycle.
- R7: The protected array region is set by block-protect. 00 protects nothing, 01 the addresses whose top two bits are 11, 10 those whose top bit is 1, and 11 every address.
- R8: The array permission flag is high only when write-enable is 1, busy is low and the target address is outside the protected region.
- R9: The status permission flag is high only when write-enable is 1, busy is low, and the lock bit is 0 or the write-protect pin is high.
- R10: A commit without permission leaves write-enable and in-progress unchanged. A permitted commit sets in-progress on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the shipped status value |
| set_wel | input | 1 | Strobe: set write-enable |
| clr_wel | input | 1 | Strobe: clear write-enable |
| stat_commit | input | 1 | Strobe: request a status-register program cycle |
| stat_data | input | 8 | Data byte for the status write |
| arr_commit | input | 1 | Strobe: request an array program cycle |
| prog_done | input | 1 | Strobe: the running program cycle has finished |
| wp_n | input | 1 | Write-protect pin, active low |
| low_vdd | input | 1 | Low-supply flag |
| tgt_addr | input | ADDR_W | Target array address for the permission check |
| status | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write permitted |
| stat_wr_ok | output | 1 | Status write permitted |
| busy | output | 1 | A program cycle is running |

## Verification
The bench walks the protection boundaries on both sides: 0xBFF against 0xC00 for the quarter, and 0x7FF against 0x800 for the half. A design with an off-by-one region decode opens a protected byte or locks a free one. The bench commits a status write and then reads during the cycle. A design that applied the new bits at once would show them early. A second status write is aborted by the low-supply flag, and a design that failed to discard the pending value would apply the new protection anyway. Refused commits, and enable strobes while busy, must leave the write-enable bit as it was. A design that lets them through would start cycles the protection forbids.

// File: rtl/wps_pkg.sv
package wps_pkg;

  // block-protect codes
  localparam logic [1:0] BP_NONE    = 2'b00;
  localparam logic [1:0] BP_QUARTER = 2'b01;
  localparam logic [1:0] BP_HALF    = 2'b10;
  localparam logic [1:0] BP_ALL     = 2'b11;

  // status byte bit positions
  localparam int unsigned SB_LOCK = 7;
  localparam int unsigned SB_BPH  = 3;
  localparam int unsigned SB_BPL  = 2;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_WIP  = 0;

  typedef struct packed {
    logic       lock;
    logic [1:0] bp;
  } nv_bits_t;

  // address region covered by a block-protect code, from the top two address bits
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    logic hit;
    case (bp)
      BP_NONE:    hit = 1'b0;
      BP_QUARTER: hit = (top2 == 2'b11);
      BP_HALF:    hit = top2[1];
      default:    hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel, input logic wip);
    logic [7:0] s;
    s          = 8'h00;
    s[SB_LOCK] = nv.lock;
    s[SB_BPH]  = nv.bp[1];
    s[SB_BPL]  = nv.bp[0];
    s[SB_WEL]  = wel;
    s[SB_WIP]  = wip;
    return s;
  endfunction

  function automatic nv_bits_t extract_nv(input logic [7:0] d);
    nv_bits_t n;
    n.lock = d[SB_LOCK];
    n.bp   = {d[SB_BPH], d[SB_BPL]};
    return n;
  endfunction

endpackage

// File: rtl/wps_wel_latch.sv
module wps_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic busy,
  input  logic cyc_end,
  input  logic low_vdd,
  output logic wel
);
  logic set_ok;
  logic clr_ok;

  assign set_ok = set_req & ~busy;
  assign clr_ok = clr_req & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (low_vdd || cyc_end || clr_ok) begin
      wel <= 1'b0;
    end else if (set_ok) begin
      wel <= 1'b1;
    end
  end
endmodule

// File: rtl/wps_prog_seq.sv
module wps_prog_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic arr_start,
  input  logic stat_start,
  input  logic prog_done,
  input  logic low_vdd,
  output logic wip,
  output logic stat_cyc,
  output logic cyc_end
);
  assign cyc_end = wip & prog_done & ~low_vdd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip      <= 1'b0;
      stat_cyc <= 1'b0;
    end else if (low_vdd || cyc_end) begin
      wip      <= 1'b0;
      stat_cyc <= 1'b0;
    end else if (!wip && (arr_start || stat_start)) begin
      wip      <= 1'b1;
      stat_cyc <= stat_start;
    end
  end
endmodule

// File: rtl/wps_nv_bits.sv
module wps_nv_bits
  import wps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  nv_bits_t new_val,
  input  logic     apply,
  input  logic     abort,
  output nv_bits_t cur
);
  nv_bits_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      pend <= '0;
    end else begin
      if (capture && !abort) begin
        pend <= new_val;
      end
      if (apply && !abort) begin
        cur <= pend;
      end
    end
  end
endmodule

// File: rtl/wps_status_ctrl.sv
module wps_status_ctrl
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              stat_commit,
  input  logic [7:0]        stat_data,
  input  logic              arr_commit,
  input  logic              prog_done,
  input  logic              wp_n,
  input  logic              low_vdd,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        status,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok,
  output logic              busy
);
  localparam int unsigned TOP_LSB = ADDR_W - 2;

  logic     wel;
  logic     wip;
  logic     stat_cyc;
  logic     cyc_end;
  logic     arr_start;
  logic     stat_start;
  logic     acc_start;
  logic     hw_lock;
  logic     addr_prot;
  nv_bits_t nv_cur;

  assign hw_lock   = nv_cur.lock & ~wp_n;
  assign addr_prot = region_locked(nv_cur.bp, tgt_addr[TOP_LSB +: 2]);

  assign arr_wr_ok  = wel & ~wip & ~addr_prot;
  assign stat_wr_ok = wel & ~wip & ~hw_lock;

  // array request has priority if both strobes coincide
  assign arr_start  = arr_commit & arr_wr_ok & ~low_vdd;
  assign stat_start = stat_commit & stat_wr_ok & ~arr_commit & ~low_vdd;
  assign acc_start  = arr_start | stat_start;

  wps_wel_latch u_wel (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_wel),
    .clr_req (clr_wel),
    .busy    (wip),
    .cyc_end (cyc_end),
    .low_vdd (low_vdd),
    .wel     (wel)
  );

  wps_prog_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_start  (arr_start),
    .stat_start (stat_start),
    .prog_done  (prog_done),
    .low_vdd    (low_vdd),
    .wip        (wip),
    .stat_cyc   (stat_cyc),
    .cyc_end    (cyc_end)
  );

  wps_nv_bits u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (stat_start),
    .new_val (extract_nv(stat_data)),
    .apply   (cyc_end & stat_cyc),
    .abort   (low_vdd),
    .cur     (nv_cur)
  );

  assign status = pack_status(nv_cur, wel, wip);
  assign busy   = wip;
endmodule

// File: rtl/wps_checker.sv
module wps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       set_wel,
  input logic       clr_wel,
  input logic       arr_commit,
  input logic       prog_done,
  input logic       wp_n,
  input logic       low_vdd,
  input logic [7:0] status,
  input logic       stat_wr_ok,
  input logic       arr_wr_ok,
  input logic       busy,
  input logic       acc_start
);
  // R2: write-enable rises only after a set strobe
  assert_wel_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(set_wel));

  // R3: completion clears write-enable and in-progress
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_done) |=> (!status[1] && !busy));

  // R4: low supply clears write-enable and in-progress
  assert_lowvdd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_vdd |=> (!status[1] && !status[0]));

  // R6: protection bits do not move inside a running cycle
  assert_nv_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[7:2]));

  // R9: lock bit with pin low refuses status writes
  assert_hw_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |-> !stat_wr_ok);

  // R10: a refused array commit changes neither write-enable nor in-progress
  assert_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_commit && !arr_wr_ok && !set_wel && !clr_wel && !low_vdd && !prog_done)
      |=> $stable(status[1:0]));

  // R10: in-progress rises only from an accepted commit
  assert_wip_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_start));
endmodule

bind wps_status_ctrl wps_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_wel    (set_wel),
  .clr_wel    (clr_wel),
  .arr_commit (arr_commit),
  .prog_done  (prog_done),
  .wp_n       (wp_n),
  .low_vdd    (low_vdd),
  .status     (status),
  .stat_wr_ok (stat_wr_ok),
  .arr_wr_ok  (arr_wr_ok),
  .busy       (busy),
  .acc_start  (acc_start)
);

// File: tb/wps_status_ctrl_tb.sv
module wps_status_ctrl_tb_top;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              set_wel, clr_wel, stat_commit, arr_commit, prog_done, wp_n, low_vdd;
  logic [7:0]        stat_data;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        status;
  logic              arr_wr_ok, stat_wr_ok, busy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wps_status_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk, .rst_n, .set_wel, .clr_wel, .stat_commit, .stat_data, .arr_commit,
    .prog_done, .wp_n, .low_vdd, .tgt_addr, .status, .arr_wr_ok, .stat_wr_ok, .busy
  );

  typedef struct packed {
    logic       sw, cw, sc, ac, pd, wp, lv;
    logic [7:0] sd;
    logic [11:0] ad;
    logic [7:0] es;
    logic       eao, eso;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  // fields: set clr scommit acommit done wp_n lowvdd data addr expStatus expArrOk expStatOk req
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,0,1,0, 8'h00, 12'h000, 8'h00, 0,0, 8},  // R8 no enable
    '{0,0,0,1,0,1,0, 8'h00, 12'h000, 8'h00, 0,0, 10}, // R10 refused
    '{1,0,0,0,0,1,0, 8'h00, 12'h000, 8'h02, 0,0, 2},  // R2 set
    '{0,0,0,0,0,1,0, 8'h00, 12'h800, 8'h02, 1,1, 8},  // R8 R9 open
    '{0,0,1,0,0,1,0, 8'hFF, 12'h000, 8'h03, 1,1, 6},  // R6 old bits shown
    '{0,0,0,0,0,1,0, 8'h00, 12'h000, 8'h03, 0,0, 8},  // busy blocks
    '{1,0,0,0,0,1,0, 8'h00, 12'h000, 8'h03, 0,0, 2},  // R2 ignored busy
    '{0,0,0,0,1,1,0, 8'h00, 12'h000, 8'h8C, 0,0, 5},  // R5 R3 apply
    '{1,0,0,0,0,1,0, 8'h00, 12'h000, 8'h8E, 0,0, 2},
    '{0,0,0,0,0,0,0, 8'h00, 12'h000, 8'h8E, 0,0, 9},  // R9 lock
    '{0,0,1,0,0,0,0, 8'h00, 12'h000, 8'h8E, 0,0, 10}, // R10 refused status
    '{0,0,1,0,0,1,0, 8'h04, 12'h000, 8'h8F, 0,1, 9},  // R9 pin high
    '{0,0,0,0,1,1,0, 8'h00, 12'h000, 8'h04, 0,0, 3},  // R3
    '{1,0,0,0,0,1,0, 8'h00, 12'h000, 8'h06, 0,0, 2},
    '{0,0,0,0,0,1,0, 8'h00, 12'hC00, 8'h06, 0,1, 7},  // R7 quarter in
    '{0,0,0,0,0,1,0, 8'h00, 12'hBFF, 8'h06, 1,1, 7},  // R7 quarter out
    '{0,0,0,1,0,1,0, 8'h00, 12'hBFF, 8'h07, 1,1, 10}, // R10 accepted
    '{0,0,0,1,0,1,0, 8'h00, 12'h000, 8'h07, 0,0, 8},  // R8 busy
    '{0,0,0,0,0,1,1, 8'h00, 12'h000, 8'h04, 0,0, 4},  // R4 abort
    '{0,0,0,0,1,1,0, 8'h00, 12'h000, 8'h04, 0,0, 3},
    '{1,0,0,0,0,1,0, 8'h00, 12'h000, 8'h06, 0,0, 2},
    '{0,1,0,0,0,1,0, 8'h00, 12'h000, 8'h04, 1,1, 2}   // R2 clear
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    set_wel = 0; clr_wel = 0; stat_commit = 0; arr_commit = 0;
    prog_done = 0; low_vdd = 0; stat_data = 8'h00;
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    wp_n = 1; tgt_addr = '0; rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset busy", busy, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_wel = VECS[i].sw; clr_wel = VECS[i].cw; stat_commit = VECS[i].sc;
      arr_commit = VECS[i].ac; prog_done = VECS[i].pd; wp_n = VECS[i].wp;
      low_vdd = VECS[i].lv; stat_data = VECS[i].sd; tgt_addr = VECS[i].ad;
      #1;
      chk($sformatf("R%0d vec%0d arr_wr_ok", VECS[i].req, i), arr_wr_ok, VECS[i].eao);
      chk($sformatf("R%0d vec%0d stat_wr_ok", VECS[i].req, i), stat_wr_ok, VECS[i].eso);
      step();
      chk($sformatf("R%0d vec%0d status", VECS[i].req, i), status, VECS[i].es);
    end
    idle_inputs();
    wp_n = 1;
    step();

    // R4: abort of a status write discards the pending value
    set_wel = 1; step(); set_wel = 0;
    stat_commit = 1; stat_data = 8'h08; step(); stat_commit = 0;
    chk("R6 old bits during cycle", status, 8'h07);
    low_vdd = 1; step(); low_vdd = 0;
    chk("R4 abort clears", status, 8'h04);
    prog_done = 1; step(); prog_done = 0;
    chk("R4 pending discarded", status, 8'h04);

    // R4: low supply wins over a simultaneous set
    set_wel = 1; low_vdd = 1; step(); set_wel = 0; low_vdd = 0;
    chk("R4 priority over set", status, 8'h04);

    // R7: half-array boundary
    set_wel = 1; step(); set_wel = 0;
    stat_commit = 1; stat_data = 8'h08; step(); stat_commit = 0;
    prog_done = 1; step(); prog_done = 0;
    chk("R5 half code applied", status, 8'h08);
    set_wel = 1; step(); set_wel = 0;
    tgt_addr = 12'h7FF; #1;
    chk("R7 half below edge", arr_wr_ok, 1'b1);
    tgt_addr = 12'h800; #1;
    chk("R7 half above edge", arr_wr_ok, 1'b0);
    arr_commit = 1; step(); arr_commit = 0;
    chk("R10 refused keeps enable", status, 8'h0A);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule